// File: doc/BRIEF.md
# Dual-Port RAM with Same-Cycle Collision Guard

This block is a synchronous dual-port RAM with two fully independent ports, A and B, running on one shared clock. Each port has its own enable, write enable, address, write data and read data. Beside the storage array, a comparator looks at both ports on every clock edge. It decides whether the two accesses collide: both write the same word, or one writes a word that the other reads in the same cycle.

A per-instance parameter sets the collision policy. The policy has two independent switches. The first decides whether a collision is reported on the per-port event outputs and on a shared flag. The second decides whether the affected data is marked untrustworthy. A reader that hits a word being written by the other port sees its read-valid bit held low. A word written by both ports at once is poisoned. From then on its reads come back with read-valid low, until a write that is not itself a collision cleans the word.

Reads have one cycle of latency and are read-first: a port that writes and reads the same address sees the old content. When both ports write one address, port A's data is kept.

Top module: `dpram_guard`

## Requirements
- R1: A port access with enable high returns, one clock edge later on that port's read data, the word as it stood before that edge. A write on the same port in the same cycle does not change what is returned.
- R2: When both ports write the same address in one cycle, the word afterwards holds port A's write data.
- R3: A same-address write on both ports in one cycle gives, on the next cycle, event code 2'b10 on both ports' event outputs, when the policy reports.
- R4: When one port reads (enable high, write enable low) an address that the other port writes in the same cycle, the reading port's event output shows 2'b01 on the next cycle and the writing port's shows 2'b00, when the policy reports. The reader's data is the word's content before the write.
- R5: A port's read-valid output is high exactly in the cycle after that port did a read (enable high, write enable low), unless R6 or R7 invalidates it. It is low after write cycles and idle cycles.
- R6: Under an invalidating policy, the reader in a read-write collision gets read-valid low for that read.
- R7: Under an invalidating policy, a word written by both ports at once becomes poisoned. Every later read of it returns read-valid low, until a write to it that is not a same-address double write clears the poison.
- R8: The policy parameter has four values, and each instance may use a different one. POL_ALL reports and invalidates. POL_REPORT_ONLY reports but never invalidates. POL_POISON_ONLY invalidates but keeps both event outputs at 2'b00. POL_QUIET does neither.
- R9: The collision flag is high in the cycle after any collision when the policy reports, and low in that cycle otherwise.
- R10: A cycle counts as no collision if both ports read the same address, if the ports use different addresses, or if either port's enable is low. Both event outputs are then 2'b00 on the next cycle.
- R11: While reset is asserted, the read-valid, event and flag outputs are low, and reset clears every poison mark. Stored data is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable (read when low) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle after the access |
| a_rvalid | output | 1 | Port A read data is trustworthy |
| a_evt | output | 2 | Port A collision event: 00 none, 01 read-write, 10 write-write |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable (read when low) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle after the access |
| b_rvalid | output | 1 | Port B read data is trustworthy |
| b_evt | output | 2 | Port B collision event, same encoding as port A |
| coll_flag | output | 1 | A collision was reported in the previous cycle |

## Verification
The properties assume that both ports sit in one clock domain. They also assume that enables, write enables and addresses carry known values at every rising edge after reset, since collision detection compares them bit by bit. The stimulus changes every input on the falling edge only. Before any read, it writes every address of the array, so no read ever returns uninitialised storage. It drives four instances, one per policy, with the same traffic, so every policy sees the same collisions.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    // Collision policy chosen per instance.
    typedef enum logic [1:0] {
        POL_ALL         = 2'd0,
        POL_REPORT_ONLY = 2'd1,
        POL_POISON_ONLY = 2'd2,
        POL_QUIET       = 2'd3
    } coll_policy_e;

    // Event codes on the per-port event outputs.
    localparam logic [1:0] EVT_NONE = 2'b00;
    localparam logic [1:0] EVT_RW   = 2'b01;
    localparam logic [1:0] EVT_WW   = 2'b10;

    localparam int NPORT = 2;

    // Classified collision of one cycle.
    typedef struct packed {
        logic ww;        // both ports write the same word
        logic a_rd_hit;  // A reads the word B writes
        logic b_rd_hit;  // B reads the word A writes
    } coll_hit_s;

    function automatic logic pol_reports(coll_policy_e p);
        return (p == POL_ALL) || (p == POL_REPORT_ONLY);
    endfunction

    function automatic logic pol_poisons(coll_policy_e p);
        return (p == POL_ALL) || (p == POL_POISON_ONLY);
    endfunction

endpackage

// File: rtl/dpg_detect.sv
module dpg_detect
    import dpg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    output coll_hit_s     hit
);

    logic same_word;
    logic both_on;

    always_comb begin
        same_word    = (a_addr == b_addr);
        both_on      = a_en && b_en;
        hit.ww       = both_on && same_word && a_we && b_we;
        hit.a_rd_hit = both_on && same_word && !a_we && b_we;
        hit.b_rd_hit = both_on && same_word && a_we && !b_we;
    end

endmodule

// File: rtl/dpg_store.sv
module dpg_store #(
    parameter int AW        = 6,
    parameter int DW        = 32,
    parameter bit POISON_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  logic          ww,
    output logic [DW-1:0] a_rdata,
    output logic [DW-1:0] b_rdata,
    output logic          a_psn,
    output logic          b_psn
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0] poison;
        logic [DW-1:0]    a_rdata;
        logic [DW-1:0]    b_rdata;
        logic             a_psn;
        logic             b_psn;
    } store_s;

    store_s st_d, st_q;

    // Storage array: not reset, content survives reset.
    logic [DW-1:0] mem_q [DEPTH];

    // Port A written last so its data is kept on a same-word double write.
    always_ff @(posedge clk) begin
        if (b_en && b_we) begin
            mem_q[b_addr] <= b_wdata;
        end
        if (a_en && a_we) begin
            mem_q[a_addr] <= a_wdata;
        end
    end

    always_comb begin
        st_d = st_q;
        // Read-first: sample the array before this edge's writes land.
        if (a_en) begin
            st_d.a_rdata = mem_q[a_addr];
            st_d.a_psn   = st_q.poison[a_addr];
        end
        if (b_en) begin
            st_d.b_rdata = mem_q[b_addr];
            st_d.b_psn   = st_q.poison[b_addr];
        end
        if (POISON_EN) begin
            if (b_en && b_we) begin
                st_d.poison[b_addr] = ww;
            end
            if (a_en && a_we) begin
                st_d.poison[a_addr] = ww;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_rdata = st_q.a_rdata;
    assign b_rdata = st_q.b_rdata;
    assign a_psn   = st_q.a_psn;
    assign b_psn   = st_q.b_psn;

endmodule

// File: rtl/dpg_port.sv
module dpg_port
    import dpg_pkg::*;
#(
    parameter bit REPORT_EN = 1'b1,
    parameter bit POISON_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       rd_hit,
    input  logic       ww_hit,
    input  logic       psn,
    output logic       rvalid,
    output logic [1:0] evt
);

    typedef struct packed {
        logic       rvalid;
        logic [1:0] evt;
    } port_s;

    port_s pt_d, pt_q;

    always_comb begin
        pt_d        = pt_q;
        pt_d.rvalid = rd && !(POISON_EN && rd_hit);
        pt_d.evt    = EVT_NONE;
        if (REPORT_EN) begin
            if (ww_hit) begin
                pt_d.evt = EVT_WW;
            end else if (rd_hit) begin
                pt_d.evt = EVT_RW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    // The poison mark comes registered from the store, aligned with the read.
    assign rvalid = pt_q.rvalid && !(POISON_EN && psn);
    assign evt    = pt_q.evt;

endmodule

// File: rtl/dpram_guard.sv
module dpram_guard
    import dpg_pkg::*;
#(
    parameter int           AW     = 6,
    parameter int           DW     = 32,
    parameter coll_policy_e POLICY = POL_ALL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_rvalid,
    output logic [1:0]    a_evt,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_rvalid,
    output logic [1:0]    b_evt,
    output logic          coll_flag
);

    localparam bit REPORT_EN = pol_reports(POLICY);
    localparam bit POISON_EN = pol_poisons(POLICY);

    coll_hit_s        hit;
    logic [NPORT-1:0] en_v, we_v, rd_hit_v, psn_v, rvalid_v;
    logic [1:0]       evt_v [NPORT];

    dpg_detect #(.AW(AW)) u_detect (
        .a_en   (a_en),
        .a_we   (a_we),
        .a_addr (a_addr),
        .b_en   (b_en),
        .b_we   (b_we),
        .b_addr (b_addr),
        .hit    (hit)
    );

    dpg_store #(.AW(AW), .DW(DW), .POISON_EN(POISON_EN)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .ww      (hit.ww),
        .a_rdata (a_rdata),
        .b_rdata (b_rdata),
        .a_psn   (psn_v[0]),
        .b_psn   (psn_v[1])
    );

    assign en_v     = {b_en, a_en};
    assign we_v     = {b_we, a_we};
    assign rd_hit_v = {hit.b_rd_hit, hit.a_rd_hit};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpg_port #(.REPORT_EN(REPORT_EN), .POISON_EN(POISON_EN)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd     (en_v[p] && !we_v[p]),
            .rd_hit (rd_hit_v[p]),
            .ww_hit (hit.ww),
            .psn    (psn_v[p]),
            .rvalid (rvalid_v[p]),
            .evt    (evt_v[p])
        );
    end

    assign a_rvalid  = rvalid_v[0];
    assign b_rvalid  = rvalid_v[1];
    assign a_evt     = evt_v[0];
    assign b_evt     = evt_v[1];
    assign coll_flag = (evt_v[0] != EVT_NONE) || (evt_v[1] != EVT_NONE);

endmodule

// File: rtl/dpram_guard_chk.sv
module dpram_guard_chk
    import dpg_pkg::*;
#(
    parameter int           AW     = 6,
    parameter coll_policy_e POLICY = POL_ALL
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic          a_rvalid,
    input logic          b_rvalid,
    input logic [1:0]    a_evt,
    input logic [1:0]    b_evt,
    input logic          coll_flag
);

    localparam bit REP = pol_reports(POLICY);
    localparam bit PSN = pol_poisons(POLICY);

    logic on_same, ww_c, rwa_c, rwb_c, any_c;
    assign on_same = a_en && b_en && (a_addr == b_addr);
    assign ww_c    = on_same && a_we && b_we;
    assign rwa_c   = on_same && !a_we && b_we;
    assign rwb_c   = on_same && a_we && !b_we;
    assign any_c   = ww_c || rwa_c || rwb_c;

    p_ww_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ww_c |=> (a_evt == (REP ? 2'b10 : 2'b00)) && (b_evt == (REP ? 2'b10 : 2'b00)));

    p_evt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(a_evt) && $onehot0(b_evt));

    p_rw_report_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rwa_c |=> (a_evt == (REP ? 2'b01 : 2'b00)) && (b_evt == 2'b00));

    p_rw_report_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rwb_c |=> (b_evt == (REP ? 2'b01 : 2'b00)) && (a_evt == 2'b00));

    p_no_read_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && !a_we) |=> !a_rvalid);

    p_no_read_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_en && !b_we) |=> !b_rvalid);

    p_rw_invalid_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rwa_c |=> (a_rvalid == !PSN));

    p_rw_invalid_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rwb_c |=> (b_rvalid == !PSN));

    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_c |=> (coll_flag == REP));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_c |=> !coll_flag && (a_evt == 2'b00) && (b_evt == 2'b00));

endmodule

bind dpram_guard dpram_guard_chk #(.AW(AW), .POLICY(POLICY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .b_en      (b_en),
    .b_we      (b_we),
    .b_addr    (b_addr),
    .a_rvalid  (a_rvalid),
    .b_rvalid  (b_rvalid),
    .a_evt     (a_evt),
    .b_evt     (b_evt),
    .coll_flag (coll_flag)
);

// File: tb/dpram_guard_tb_top.sv
module dpram_guard_tb_top;
    import dpg_pkg::*;

    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int NI    = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;

    logic [DW-1:0] rd_a [NI];
    logic [DW-1:0] rd_b [NI];
    logic          rv_a [NI];
    logic          rv_b [NI];
    logic [1:0]    ev_a [NI];
    logic [1:0]    ev_b [NI];
    logic          flg  [NI];

    dpram_guard #(.AW(AW), .DW(DW), .POLICY(POL_ALL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd_a[0]), .a_rvalid(rv_a[0]), .a_evt(ev_a[0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd_b[0]), .b_rvalid(rv_b[0]), .b_evt(ev_b[0]),
        .coll_flag(flg[0]));

    dpram_guard #(.AW(AW), .DW(DW), .POLICY(POL_REPORT_ONLY)) dut_rep_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd_a[1]), .a_rvalid(rv_a[1]), .a_evt(ev_a[1]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd_b[1]), .b_rvalid(rv_b[1]), .b_evt(ev_b[1]),
        .coll_flag(flg[1]));

    dpram_guard #(.AW(AW), .DW(DW), .POLICY(POL_POISON_ONLY)) dut_psn_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd_a[2]), .a_rvalid(rv_a[2]), .a_evt(ev_a[2]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd_b[2]), .b_rvalid(rv_b[2]), .b_evt(ev_b[2]),
        .coll_flag(flg[2]));

    dpram_guard #(.AW(AW), .DW(DW), .POLICY(POL_QUIET)) dut_quiet_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(rd_a[3]), .a_rvalid(rv_a[3]), .a_evt(ev_a[3]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(rd_b[3]), .b_rvalid(rv_b[3]), .b_evt(ev_b[3]),
        .coll_flag(flg[3]));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    logic [DW-1:0] mem_m [DEPTH];
    bit            psn_m [DEPTH];
    bit            wwd_m [DEPTH];

    // Expected values for the cycle after the current stimulus.
    bit            x_rv_a [NI];
    bit            x_rv_b [NI];
    logic [1:0]    x_ev_a [NI];
    logic [1:0]    x_ev_b [NI];
    bit            x_flg  [NI];
    string         t_rv_a [NI];
    string         t_rv_b [NI];
    string         t_ev;
    string         t_flg  [NI];
    logic [DW-1:0] x_rd_a, x_rd_b;
    string         t_rd_a, t_rd_b;

    function automatic bit reps(int p);
        return (p == 0) || (p == 1);
    endfunction

    function automatic bit psns(int p);
        return (p == 0) || (p == 2);
    endfunction

    task automatic check(string tag, string what, int p, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst%0d %s: actual %h expected %h", tag, p, what, act, exp);
        end
    endtask

    function automatic string rv_tag(int p, bit rd, bit rw, bit poisoned);
        if (!rd) return "R5";
        if (rw) return psns(p) ? "R6" : "R8";
        if (poisoned) return psns(p) ? "R7" : "R8";
        return "R5";
    endfunction

    task automatic step(input bit ae, input bit aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input bit be, input bit bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        bit same, ww, rwa, rwb, rda, rdb;
        a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
        same = ae && be && (aa == ba);
        ww   = same && aw && bw;
        rwa  = same && !aw && bw;
        rwb  = same && aw && !bw;
        rda  = ae && !aw;
        rdb  = be && !bw;
        t_ev = ww ? "R3" : ((rwa || rwb) ? "R4" : "R10");
        for (int p = 0; p < NI; p++) begin
            x_rv_a[p] = rda && !(psns(p) && (rwa || psn_m[aa]));
            x_rv_b[p] = rdb && !(psns(p) && (rwb || psn_m[ba]));
            t_rv_a[p] = rv_tag(p, rda, rwa, psn_m[aa]);
            t_rv_b[p] = rv_tag(p, rdb, rwb, psn_m[ba]);
            x_ev_a[p] = !reps(p) ? 2'b00 : (ww ? 2'b10 : (rwa ? 2'b01 : 2'b00));
            x_ev_b[p] = !reps(p) ? 2'b00 : (ww ? 2'b10 : (rwb ? 2'b01 : 2'b00));
            x_flg[p]  = reps(p) && (ww || rwa || rwb);
            t_flg[p]  = (!reps(p) && (ww || rwa || rwb)) ? "R8" : "R9";
        end
        // Read-first: data before this edge's writes.
        x_rd_a = mem_m[aa];
        x_rd_b = mem_m[ba];
        t_rd_a = wwd_m[aa] ? "R2" : "R1";
        t_rd_b = wwd_m[ba] ? "R2" : "R1";
        // Model update, port A wins a double write.
        if (be && bw) begin mem_m[ba] = bd; psn_m[ba] = ww; wwd_m[ba] = ww; end
        if (ae && aw) begin mem_m[aa] = ad; psn_m[aa] = ww; wwd_m[aa] = ww; end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NI; p++) begin
            check(t_rv_a[p], "a_rvalid", p, DW'(rv_a[p]), DW'(x_rv_a[p]));
            check(t_rv_b[p], "b_rvalid", p, DW'(rv_b[p]), DW'(x_rv_b[p]));
            if (x_rv_a[p]) check(t_rd_a, "a_rdata", p, rd_a[p], x_rd_a);
            if (x_rv_b[p]) check(t_rd_b, "b_rdata", p, rd_b[p], x_rd_b);
            check(reps(p) ? t_ev : "R8", "a_evt", p, DW'(ev_a[p]), DW'(x_ev_a[p]));
            check(reps(p) ? t_ev : "R8", "b_evt", p, DW'(ev_b[p]), DW'(x_ev_b[p]));
            check(t_flg[p], "coll_flag", p, DW'(flg[p]), DW'(x_flg[p]));
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic check_reset_outputs();
        for (int p = 0; p < NI; p++) begin
            check("R11", "a_rvalid", p, DW'(rv_a[p]), '0);
            check("R11", "b_rvalid", p, DW'(rv_b[p]), '0);
            check("R11", "a_evt", p, DW'(ev_a[p]), '0);
            check("R11", "b_evt", p, DW'(ev_b[p]), '0);
            check("R11", "coll_flag", p, DW'(flg[p]), '0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            psn_m[i] = 1'b0;
            wwd_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst_n = 1'b1;

        // Fill the array: A takes even words, B odd words.
        for (int i = 0; i < DEPTH / 2; i++) begin
            step(1'b1, 1'b1, AW'(2 * i), DW'(32'h1000 + 2 * i),
                 1'b1, 1'b1, AW'(2 * i + 1), DW'(32'h1000 + 2 * i + 1));
        end
        idle();

        // R1: plain reads on both ports.
        step(1'b1, 1'b0, AW'(5), '0, 1'b1, 1'b0, AW'(6), '0);
        // R1: read-first on a same-port write.
        step(1'b1, 1'b1, AW'(5), 32'hAAAA_0005, 1'b0, 1'b0, '0, '0);
        step(1'b1, 1'b0, AW'(5), '0, 1'b0, 1'b0, '0, '0);

        // R2, R3, R7: double write then repeated reads of the poisoned word.
        step(1'b1, 1'b1, AW'(9), 32'h0000_0111, 1'b1, 1'b1, AW'(9), 32'h0000_0222);
        step(1'b1, 1'b0, AW'(9), '0, 1'b0, 1'b0, '0, '0);
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, AW'(9), '0);
        // R7: a clean write clears the poison.
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, AW'(9), 32'h0000_0333);
        step(1'b1, 1'b0, AW'(9), '0, 1'b0, 1'b0, '0, '0);

        // R4, R6: read-write collisions in both directions.
        step(1'b1, 1'b1, AW'(12), 32'hC0C0_0012, 1'b1, 1'b0, AW'(12), '0);
        step(1'b1, 1'b0, AW'(13), '0, 1'b1, 1'b1, AW'(13), 32'hD0D0_0013);
        step(1'b1, 1'b0, AW'(13), '0, 1'b1, 1'b0, AW'(12), '0);

        // R10: same-address reads, distinct addresses, a disabled port.
        step(1'b1, 1'b0, AW'(20), '0, 1'b1, 1'b0, AW'(20), '0);
        step(1'b1, 1'b1, AW'(21), 32'h0000_0021, 1'b1, 1'b1, AW'(22), 32'h0000_0022);
        step(1'b0, 1'b1, AW'(30), 32'hBAD0_0030, 1'b1, 1'b1, AW'(30), 32'h0000_0030);
        step(1'b1, 1'b0, AW'(30), '0, 1'b1, 1'b0, AW'(21), '0);

        // R11: poison a word, reset, and read it back as clean.
        step(1'b1, 1'b1, AW'(40), 32'h0000_4040, 1'b1, 1'b1, AW'(40), 32'h0000_4141);
        a_en = 1'b0; b_en = 1'b0; a_we = 1'b0; b_we = 1'b0;
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) psn_m[i] = 1'b0;
        @(negedge clk);
        check_reset_outputs();
        rst_n = 1'b1;
        step(1'b1, 1'b0, AW'(40), '0, 1'b1, 1'b0, AW'(40), '0);

        // Mixed traffic on a narrow address window to force collisions.
        for (int i = 0; i < 2000; i++) begin
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 AW'($urandom_range(0, 3)), DW'($urandom),
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 AW'($urandom_range(0, 3)), DW'($urandom));
        end
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule